// File: doc/BRIEF.md
# Pointer-Addressed Dual-Read Word Memory

This block stores a large operand as 256 words of 32 bits and lets a host move it in and out over a narrow register interface that has no address bus. The host first pulses a pointer-clear strobe. Each cycle in which it then asserts select accesses the word under an internal pointer, and the pointer steps forward by one. A write happens when the write qualifier is also high. For a read, the word under the pointer is already visible on the host data output before the clock edge that advances the pointer.

A second, independent port serves a compute engine. It reads any word by explicit 8-bit address, and the data appears one cycle later. It never disturbs the host pointer.

A build-time kind parameter selects one of two variants. In the operand variant, the host owns the write path. In the result variant, the engine writes by explicit address and the host can only read through the pointer. Reset is asynchronous and active low. It clears the pointer and the engine read register, and leaves the stored words untouched.

Top module: `ptr_word_store`

## Requirements
- R1: While rst_n is low, eng_rdata is 0 and the pointer is 0. Stored words survive reset, so after reset host_rdata shows the word that was at index 0 before it.
- R2: In the operand variant, after a pointer clear, successive cycles with host_sel=1 and host_wr=1 write host_wdata into words 0, 1, 2, ... in order.
- R3: host_rdata combinationally shows the word at the pointer. After a pointer clear, successive cycles with host_sel=1 present words 0, 1, 2, ... in order.
- R4: The pointer advances only on a clock edge with host_sel=1. A cycle with host_sel=0 neither moves the pointer nor writes, whatever the value of host_wr.
- R5: ptr_clr takes priority over an increment in the same cycle: the pointer becomes 0.
- R6: The pointer is 8 bits wide and wraps from 255 to 0 without error.
- R7: eng_rdata equals the word at eng_raddr one cycle after that address is presented. This holds for every address, including in cycles with host accesses.
- R8: When a write and an engine read hit the same word in the same cycle, eng_rdata returns the old content. The new content is seen on the following read.
- R9: In the result variant (KIND=KIND_RESULT), eng_we=1 writes eng_wdata to word eng_waddr. host_wr is ignored: host accesses only read and advance the pointer.
- R10: In the operand variant (default KIND=KIND_OPERAND), eng_we, eng_waddr and eng_wdata have no effect on the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_clr | input | 1 | Return the host pointer to word 0 |
| host_sel | input | 1 | Host access this cycle; advances the pointer |
| host_wr | input | 1 | Host access is a write (operand variant only) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at the current pointer, combinational |
| eng_raddr | input | 8 | Engine read address |
| eng_rdata | output | 32 | Engine read data, one cycle after address |
| eng_we | input | 1 | Engine write enable (result variant only) |
| eng_waddr | input | 8 | Engine write address |
| eng_wdata | input | 32 | Engine write data |

## Verification
A pointer that skips, sticks or fails to clear shows on host_rdata in the very next cycle, because that output follows the pointer without a register. A full sequential sweep with distinct per-word values therefore exposes the fault at the first wrong index. A write landing at the wrong index, or an engine write leaking into the operand variant, is only seen when that word is read back, so every word is read back through both ports. An engine read with the wrong latency or wrong ordering against a write shows up as a one-cycle shift against the expected word. That shift is caught right after it happens, when a same-address write and read collide.

// File: rtl/ptrmem_pkg.sv
package ptrmem_pkg;

    // Which side owns the write path.
    typedef enum logic {
        KIND_OPERAND = 1'b0,
        KIND_RESULT  = 1'b1
    } store_kind_e;

endpackage

// File: rtl/ptrmem_pointer.sv
module ptrmem_pointer #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    // Clear wins over step; natural wrap at 2**AW.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R5
    ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(ptr));

endmodule

// File: rtl/ptrmem_array.sv
module ptrmem_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] ptr_addr,
    output logic [DW-1:0] ptr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Contents are never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Host side: asynchronous read at the pointer.
    assign ptr_data = mem[ptr_addr];

    // Engine side: registered read, old data on collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

    // R7
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && (rd_addr == $past(wr_addr))) |=> (rd_data == $past(wr_data, 2)));

endmodule

// File: rtl/ptr_word_store.sv
module ptr_word_store #(
    parameter int                      DEPTH = 256,
    parameter int                      DW    = 32,
    parameter ptrmem_pkg::store_kind_e KIND  = ptrmem_pkg::KIND_OPERAND,
    localparam int                     AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_clr,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [DW-1:0] eng_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [DW-1:0] eng_wdata
);

    localparam bit ENGINE_OWNS_WRITE = (KIND == ptrmem_pkg::KIND_RESULT);

    logic [AW-1:0] ptr_q;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    // Write-path ownership chosen at build time.
    assign wr_en   = ENGINE_OWNS_WRITE ? eng_we    : (host_sel & host_wr);
    assign wr_addr = ENGINE_OWNS_WRITE ? eng_waddr : ptr_q;
    assign wr_data = ENGINE_OWNS_WRITE ? eng_wdata : host_wdata;

    ptrmem_pointer #(.AW(AW)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .step  (host_sel),
        .ptr   (ptr_q)
    );

    ptrmem_array #(.DEPTH(DEPTH), .DW(DW)) mem_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ptr_addr (ptr_q),
        .ptr_data (host_rdata),
        .rd_addr  (eng_raddr),
        .rd_data  (eng_rdata)
    );

    generate
        if (!ENGINE_OWNS_WRITE) begin : g_operand
            // R4
            host_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ptr_clr && !host_sel) |=> $stable(host_rdata));
        end
    endgenerate

endmodule

// File: tb/ptr_word_store_tb_top.sv
module ptr_word_store_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_clr = 1'b0, host_sel = 1'b0, host_wr = 1'b0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [7:0]  eng_raddr = '0, eng_waddr = '0;
    logic [31:0] eng_rdata, eng_wdata = '0;
    logic        eng_we = 1'b0;

    logic        r_clr = 1'b0, r_sel = 1'b0, r_wr = 1'b0, r_we = 1'b0;
    logic [31:0] r_hwdata = '0, r_hrdata, r_erdata, r_ewdata = '0;
    logic [7:0]  r_raddr = '0, r_waddr = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptr_word_store dut_i (
        .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .host_sel(host_sel),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .eng_we(eng_we),
        .eng_waddr(eng_waddr), .eng_wdata(eng_wdata)
    );

    ptr_word_store #(.KIND(ptrmem_pkg::KIND_RESULT)) dut_r (
        .clk(clk), .rst_n(rst_n), .ptr_clr(r_clr), .host_sel(r_sel),
        .host_wr(r_wr), .host_wdata(r_hwdata), .host_rdata(r_hrdata),
        .eng_raddr(r_raddr), .eng_rdata(r_erdata), .eng_we(r_we),
        .eng_waddr(r_waddr), .eng_wdata(r_ewdata)
    );

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h3C5A_0F00;
    endfunction

    function automatic logic [31:0] rpat(int i);
        return ~pat(i) + 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog got=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] newv;
        newv = 32'hDEAD_BEEF;
        #1;
        // R1: engine read register is cleared during reset
        check("R1 eng_rdata in reset", eng_rdata, 32'h0);
        check("R1 result eng_rdata in reset", r_erdata, 32'h0);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R2: fill all words in order
        ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
        host_sel = 1'b1; host_wr = 1'b1;
        for (int i = 0; i < 256; i++) begin
            host_wdata = pat(i);
            cyc();
        end
        host_sel = 1'b0; host_wr = 1'b0;

        // R3: read back in order; R2 verified by content
        ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
        host_sel = 1'b1;
        for (int i = 0; i < 256; i++) begin
            check("R2/R3 sequential read", host_rdata, pat(i));
            cyc();
        end
        host_sel = 1'b0;
        // R6: after 256 steps the pointer is back at word 0
        check("R6 wrap to 0", host_rdata, pat(0));

        // R4: idle cycles with host_wr high neither move nor write
        host_wr = 1'b1; host_wdata = 32'h1111_2222;
        for (int k = 0; k < 3; k++) begin
            cyc();
            check("R4 idle holds pointer", host_rdata, pat(0));
        end
        host_wr = 1'b0;
        host_sel = 1'b1; cyc(); host_sel = 1'b0;
        check("R4 single advance", host_rdata, pat(1));
        eng_raddr = 8'd0; cyc();
        check("R4 no write while idle", eng_rdata, pat(0));

        // R5: clear and select together
        host_sel = 1'b1; cyc(); cyc();
        check("R5 pointer before clear", host_rdata, pat(3));
        ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0; host_sel = 1'b0;
        check("R5 clear beats increment", host_rdata, pat(0));

        // R7: engine sweep concurrent with host reads
        host_sel = 1'b1;
        for (int i = 0; i < 256; i++) begin
            eng_raddr = 8'(255 - i);
            check("R7 host read during engine read", host_rdata, pat(i));
            cyc();
            check("R7 engine read latency", eng_rdata, pat(255 - i));
        end
        host_sel = 1'b0;

        // R10: engine write inputs ignored in operand variant
        eng_we = 1'b1; eng_waddr = 8'd5; eng_wdata = 32'hBAD0_BAD0;
        cyc(); cyc();
        eng_we = 1'b0;
        eng_raddr = 8'd5; cyc();
        check("R10 engine write ignored", eng_rdata, pat(5));

        // R8: same-cycle write and engine read of word 0
        ptr_clr = 1'b1; cyc(); ptr_clr = 1'b0;
        eng_raddr = 8'd0;
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = newv;
        cyc();
        host_sel = 1'b0; host_wr = 1'b0;
        check("R8 old data on collision", eng_rdata, pat(0));
        cyc();
        check("R8 new data next read", eng_rdata, newv);

        // R1: reset clears pointer and register, keeps contents
        eng_raddr = 8'd9;
        host_sel = 1'b1; cyc(); cyc(); host_sel = 1'b0;
        rst_n = 1'b0; #1;
        check("R1 eng_rdata cleared", eng_rdata, 32'h0);
        cyc();
        rst_n = 1'b1; #1;
        check("R1 pointer 0 and contents kept", host_rdata, newv);
        cyc();
        check("R1 word 9 kept", eng_rdata, pat(9));

        // R9: result variant, engine writes descending
        r_we = 1'b1;
        for (int i = 255; i >= 0; i--) begin
            r_waddr = 8'(i); r_ewdata = rpat(i);
            cyc();
        end
        r_we = 1'b0;
        r_clr = 1'b1; cyc(); r_clr = 1'b0;
        r_sel = 1'b1; r_wr = 1'b1; r_hwdata = 32'hFFFF_0000;
        for (int i = 0; i < 256; i++) begin
            check("R9 host reads engine-written words", r_hrdata, rpat(i));
            cyc();
        end
        r_sel = 1'b0; r_wr = 1'b0;
        for (int a = 0; a < 4; a++) begin
            r_raddr = 8'(a); cyc();
            check("R9 host_wr ignored", r_erdata, rpat(a));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule